// File: doc/BRIEF.md
# Page-Buffered Flash Write Engine

This block carries out the modifying commands of a serial flash memory: rewrite of a whole page, bit-clearing program of a page, erase of one page and erase of one sector. A command front end gives it a decoded operation code and a byte address once per chip-select frame, followed by the data bits one at a time, most significant bit first. The engine gathers the bytes into a page-sized staging buffer. The command takes effect only when chip select returns high. The engine then walks the target range of a byte-wide array through a synchronous port, one read-modify-write per byte.

A busy flag stands in for the operation's duration. It stays high for a configured number of clock cycles per operation. For page program that count grows with the number of bytes supplied. Every modifying command needs a prior write-enable command. The latch this sets is cleared when the cycle completes. While the write-protect input is low, the lowest sector of the array refuses modification. A second read port lets the front end fetch array bytes. Durations are parameters in clock cycles, and each must exceed twice the span of the operation plus one.

Top module: `fwe_write_engine`

## Requirements
- R1: After reset, `busy` and `wel` are both 0.
- R2: A frame with operation code 1 (enable) sets `wel`, and one with code 2 (disable) clears it. Either takes effect at the rising edge of `cs_n` while the engine is idle.
- R3: A modifying command (code 3 page rewrite, 4 page program, 5 page erase, 6 sector erase) sent while `wel` is 0 starts no cycle and leaves the array unchanged.
- R4: Page rewrite sets every byte of the addressed page to FFh and then stores the supplied bytes. `busy` is high for exactly `T_PW` cycles.
- R5: Page program replaces each supplied byte position with the old value ANDed with the new byte, so bits can only clear. `busy` is high for exactly `T_PP_BASE + n*T_PP_BYTE` cycles, where n is the number of bytes received, capped at one page.
- R6: Page erase sets every byte of the addressed page to FFh, leaves other pages alone, and holds `busy` for exactly `T_PE` cycles.
- R7: Sector erase sets every byte of the addressed sector to FFh and holds `busy` for exactly `T_SE` cycles.
- R8: Data bytes start at the page offset given by the low address bits and wrap to offset 0 of the same page. When more bytes than a page are sent, only the last page-worth is kept.
- R9: A frame whose data ends with a partial byte, or a page rewrite or page program with no data byte, is discarded.
- R10: While `wp_n` is low at the end of the frame, any modifying command aimed at the lowest sector is not executed. Commands aimed at other sectors run normally, and with `wp_n` high the lowest sector is writable.
- R11: A frame that begins while `busy` is high is dropped, and the running cycle keeps its duration and result.
- R12: `wel` clears when a cycle completes and stays set after a command that was refused.
- R13: `rd_data` shows the array byte at `rd_addr` one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, low during a frame |
| cmd_valid | input | 1 | Operation code and address are valid this cycle |
| cmd_op | input | 3 | Operation code (1 enable, 2 disable, 3 rewrite, 4 program, 5 page erase, 6 sector erase) |
| cmd_addr | input | AW | Byte address of the command |
| din_valid | input | 1 | A data bit is present this cycle |
| din | input | 1 | Serial data bit, most significant first |
| wp_n | input | 1 | Write protect, low protects the lowest sector |
| rd_addr | input | AW | Array read address |
| rd_data | output | 8 | Array read data, one cycle latency |
| busy | output | 1 | A modifying cycle is in progress |
| wel | output | 1 | Write-enable latch |

## Verification
On every cycle, the assertions check the following. A cycle can begin only from an idle timer with the latch set. The latch is clear once busy falls. The byte walk never runs outside the busy window. A program step never sets a bit. No write lands in the lowest sector unless protection was off when that cycle was accepted. Exact busy lengths, wrap-around and last-page-kept ordering, rejection of partial and protected frames, and the final array contents can only be shown by the bench's scenarios. These compare every byte of the affected pages against a model in the bench.

// File: rtl/fwe_pkg.sv
// Shared operation codes for the page-buffered write engine.
package fwe_pkg;
    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_WREN   = 3'd1,
        OP_WRDI   = 3'd2,
        OP_PWRITE = 3'd3,
        OP_PPROG  = 3'd4,
        OP_PERASE = 3'd5,
        OP_SERASE = 3'd6
    } op_e;

    // True for the four commands that modify the array.
    function automatic logic is_modify(op_e op);
        return (op == OP_PWRITE) || (op == OP_PPROG) ||
               (op == OP_PERASE) || (op == OP_SERASE);
    endfunction

    // True for the commands that carry data bytes.
    function automatic logic needs_data(op_e op);
        return (op == OP_PWRITE) || (op == OP_PPROG);
    endfunction
endpackage

// File: rtl/fwe_page_buffer.sv
// Page staging buffer: assembles serial bits into bytes and stores each byte
// at a wrapping page offset, with a per-slot valid flag.
// Assumes: frame_clear pulses at frame start, off_load pulses with the
// command's start offset, and collect_en is low while a cycle is running.
module fwe_page_buffer #(
    parameter int PAGE_BYTES = 256,
    localparam int OFF_W = $clog2(PAGE_BYTES),
    localparam int CNT_W = OFF_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_clear,
    input  logic             off_load,
    input  logic [OFF_W-1:0] off_val,
    input  logic             collect_en,
    input  logic             bit_valid,
    input  logic             bit_in,
    input  logic [OFF_W-1:0] rd_off,
    output logic             rd_valid,
    output logic [7:0]       rd_byte,
    output logic [CNT_W-1:0] byte_count,
    output logic             partial
);
    logic [6:0]            shift_q;
    logic [2:0]            bit_idx_q;
    logic [OFF_W-1:0]      wr_off_q;
    logic [PAGE_BYTES-1:0] valid_q;
    logic [7:0]            data_q [PAGE_BYTES];
    logic                  take;
    logic                  byte_done;

    assign take      = collect_en && bit_valid;
    assign byte_done = take && (bit_idx_q == 3'd7);

    // Bit assembly, slot pointer, valid flags and saturating byte count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q    <= '0;
            bit_idx_q  <= '0;
            wr_off_q   <= '0;
            valid_q    <= '0;
            byte_count <= '0;
        end else begin
            if (frame_clear) begin
                bit_idx_q  <= '0;
                valid_q    <= '0;
                byte_count <= '0;
            end else if (take) begin
                shift_q   <= {shift_q[5:0], bit_in};
                bit_idx_q <= bit_idx_q + 3'd1;
                if (byte_done) begin
                    valid_q[wr_off_q] <= 1'b1;
                    wr_off_q          <= wr_off_q + 1'b1;
                    if (byte_count != CNT_W'(PAGE_BYTES))
                        byte_count <= byte_count + 1'b1;
                end
            end
            if (off_load)
                wr_off_q <= off_val;
        end
    end

    // Byte storage; later bytes for the same slot overwrite earlier ones.
    always_ff @(posedge clk) begin
        if (byte_done && !frame_clear)
            data_q[wr_off_q] <= {shift_q, bit_in};
    end

    assign rd_valid = valid_q[rd_off];
    assign rd_byte  = data_q[rd_off];
    assign partial  = (bit_idx_q != 3'd0);

    // R8
    slot_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && !frame_clear && !off_load) |=>
            (valid_q[$past(wr_off_q)] && byte_count != '0));
endmodule

// File: rtl/fwe_cycle_timer.sv
// Down-counter that holds busy for exactly the loaded number of cycles.
// Assumes: load is only raised while idle and load_val is at least 1.
module fwe_cycle_timer #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
    assign last = (cnt_q == CNT_W'(1));

    // R11
    load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy);
    // R11
    load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy);
endmodule

// File: rtl/fwe_byte_array.sv
// Byte-wide storage array with one write port and two registered read ports.
// Assumes: contents are not reset; software erases before relying on them.
module fwe_byte_array #(
    parameter int DEPTH = 4096,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] a_addr,
    output logic [7:0]    a_data,
    input  logic [AW-1:0] b_addr,
    output logic [7:0]    b_data
);
    logic [7:0] mem [DEPTH];

    // Write port and both synchronous read ports.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
        a_data <= mem[a_addr];
        b_data <= mem[b_addr];
    end
endmodule

// File: rtl/fwe_write_engine.sv
// Page-buffered write engine: frames commands by chip select, gathers data,
// checks enable latch, protection and framing at chip-select release, then
// walks the target range with a two-cycle read-modify-write per byte while
// a timer holds busy for the configured duration.
// Assumes: SECTORS >= 2, PAGES a multiple of SECTORS, every duration at
// least 2*span+1 cycles so the byte walk ends inside the busy window.
module fwe_write_engine
    import fwe_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    parameter int PAGES      = 16,
    parameter int SECTORS    = 4,
    parameter int TIMER_W    = 24,
    parameter int T_PW       = 600,
    parameter int T_PP_BASE  = 520,
    parameter int T_PP_BYTE  = 2,
    parameter int T_PE       = 560,
    parameter int T_SE       = 2100,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int DEPTH     = PAGE_BYTES * PAGES,
    localparam int AW        = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic          din_valid,
    input  logic          din,
    input  logic          wp_n,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          busy,
    output logic          wel
);
    localparam int SEC_BYTES = DEPTH / SECTORS;
    localparam int SEC_W     = $clog2(SEC_BYTES);
    localparam int CNT_W     = OFF_W + 1;

    // ---------------- frame tracking ----------------
    logic          cs_q, fall, rise;
    logic          frame_ok_q, cmd_seen_q, cmd_take;
    op_e           op_q;
    logic [AW-1:0] addr_q;

    assign fall     = !cs_n && cs_q;
    assign rise     = cs_n && !cs_q;
    assign cmd_take = cmd_valid && !cs_n && (fall || !cmd_seen_q);

    // Chip-select edge history, frame validity and latched command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q       <= 1'b1;
            frame_ok_q <= 1'b0;
            cmd_seen_q <= 1'b0;
            op_q       <= OP_NONE;
            addr_q     <= '0;
        end else begin
            cs_q <= cs_n;
            if (fall) begin
                frame_ok_q <= !busy;
                cmd_seen_q <= 1'b0;
            end
            if (cmd_take) begin
                cmd_seen_q <= 1'b1;
                op_q       <= op_e'(cmd_op);
                addr_q     <= cmd_addr;
            end
        end
    end

    // ---------------- staging buffer ----------------
    logic             buf_valid, partial;
    logic [7:0]       buf_byte;
    logic [CNT_W-1:0] byte_count;
    logic [AW-1:0]    cur_q;

    fwe_page_buffer #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_clear(fall && !busy),
        .off_load   (cmd_take),
        .off_val    (cmd_addr[OFF_W-1:0]),
        .collect_en (!cs_n && !fall && cmd_seen_q && frame_ok_q && !busy),
        .bit_valid  (din_valid),
        .bit_in     (din),
        .rd_off     (cur_q[OFF_W-1:0]),
        .rd_valid   (buf_valid),
        .rd_byte    (buf_byte),
        .byte_count (byte_count),
        .partial    (partial)
    );

    // ---------------- acceptance ----------------
    logic               frame_good, prot_hit, accept;
    logic               timer_last;
    logic [TIMER_W-1:0] load_val;

    assign frame_good = rise && cmd_seen_q && frame_ok_q && !busy && !partial;
    assign prot_hit   = !wp_n && (addr_q < AW'(SEC_BYTES));
    assign accept     = frame_good && is_modify(op_q) && wel &&
                        !(needs_data(op_q) && byte_count == '0) && !prot_hit;

    // Duration selected by the accepted operation.
    always_comb begin
        unique case (op_q)
            OP_PWRITE: load_val = TIMER_W'(T_PW);
            OP_PPROG:  load_val = TIMER_W'(T_PP_BASE) +
                                  TIMER_W'(byte_count) * TIMER_W'(T_PP_BYTE);
            OP_PERASE: load_val = TIMER_W'(T_PE);
            default:   load_val = TIMER_W'(T_SE);
        endcase
    end

    fwe_cycle_timer #(.CNT_W(TIMER_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .load_val(load_val),
        .busy    (busy),
        .last    (timer_last)
    );

    // Write-enable latch: set/clear by frame, cleared at cycle end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wel <= 1'b0;
        else if (timer_last)
            wel <= 1'b0;
        else if (frame_good && op_q == OP_WREN)
            wel <= 1'b1;
        else if (frame_good && op_q == OP_WRDI)
            wel <= 1'b0;
    end

    // ---------------- byte walk ----------------
    logic          seq_active_q, seq_wr_q, wp_start_q;
    op_e           seq_op_q;
    logic [AW-1:0] rem_q;
    logic          mem_we;
    logic [7:0]    mem_old, mem_new;

    // Range walk: read phase then write phase for each byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_active_q <= 1'b0;
            seq_wr_q     <= 1'b0;
            wp_start_q   <= 1'b1;
            seq_op_q     <= OP_NONE;
            cur_q        <= '0;
            rem_q        <= '0;
        end else if (accept) begin
            seq_active_q <= 1'b1;
            seq_wr_q     <= 1'b0;
            wp_start_q   <= wp_n;
            seq_op_q     <= op_q;
            if (op_q == OP_SERASE) begin
                cur_q <= {addr_q[AW-1:SEC_W], {SEC_W{1'b0}}};
                rem_q <= AW'(SEC_BYTES - 1);
            end else begin
                cur_q <= {addr_q[AW-1:OFF_W], {OFF_W{1'b0}}};
                rem_q <= AW'(PAGE_BYTES - 1);
            end
        end else if (seq_active_q) begin
            seq_wr_q <= !seq_wr_q;
            if (seq_wr_q) begin
                if (rem_q == '0) begin
                    seq_active_q <= 1'b0;
                end else begin
                    cur_q <= cur_q + 1'b1;
                    rem_q <= rem_q - 1'b1;
                end
            end
        end
    end

    assign mem_we = seq_active_q && seq_wr_q;

    // New byte value from the operation, old byte and staged byte.
    always_comb begin
        unique case (seq_op_q)
            OP_PWRITE: mem_new = buf_valid ? buf_byte : 8'hFF;
            OP_PPROG:  mem_new = buf_valid ? (mem_old & buf_byte) : mem_old;
            default:   mem_new = 8'hFF;
        endcase
    end

    fwe_byte_array #(.DEPTH(DEPTH)) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr (cur_q),
        .wdata (mem_new),
        .a_addr(cur_q),
        .a_data(mem_old),
        .b_addr(rd_addr),
        .b_data(rd_data)
    );

    // R3
    wel_before_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel));
    // R12
    wel_clear_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);
    // R11
    walk_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_active_q |-> busy);
    // R5
    program_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && seq_op_q == OP_PPROG) |-> ((mem_new & ~mem_old) == 8'h00));
    // R10
    protect_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && cur_q < AW'(SEC_BYTES)) |-> wp_start_q);
endmodule

// File: tb/tb_fwe_write_engine.sv
`timescale 1ns/1ps
module tb_fwe_write_engine;
    localparam int PB = 16, PG = 8, SC = 2;
    localparam int DEP = PB * PG, SECB = DEP / SC, AW = 7;
    localparam int T_PW = 40, T_PPB = 34, T_PPY = 1, T_PE = 36, T_SE = 140;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0, cs_n = 1'b1, cmd_valid = 1'b0, din_valid = 1'b0, din = 1'b0;
    logic wp_n = 1'b1;
    logic [2:0] cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0, rd_addr = '0;
    logic [7:0] rd_data;
    logic busy, wel;

    fwe_write_engine #(.PAGE_BYTES(PB), .PAGES(PG), .SECTORS(SC), .TIMER_W(16),
        .T_PW(T_PW), .T_PP_BASE(T_PPB), .T_PP_BYTE(T_PPY), .T_PE(T_PE), .T_SE(T_SE)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .din_valid(din_valid), .din(din), .wp_n(wp_n),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .wel(wel));

    int errors = 0, checks = 0, busy_run = 0;
    logic [7:0] model [DEP];

    always @(negedge clk) if (busy === 1'b1) busy_run++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] bval(input int seed, input int k);
        return 8'(seed * 53 + k * 29 + 7);
    endfunction

    task automatic frame(input int op, input int addr, input int n, input int seed, input int extra);
        @(negedge clk) cs_n = 1'b0;
        @(negedge clk) begin cmd_valid = 1'b1; cmd_op = 3'(op); cmd_addr = AW'(addr); end
        @(negedge clk) cmd_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            logic [7:0] b;
            b = bval(seed, k);
            for (int i = 7; i >= 0; i--) begin
                din_valid = 1'b1; din = b[i];
                @(negedge clk);
            end
        end
        for (int e = 0; e < extra; e++) begin
            din_valid = 1'b1; din = 1'b1;
            @(negedge clk);
        end
        din_valid = 1'b0;
        cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        while (busy !== 1'b0) @(negedge clk);
    endtask

    task automatic run(input int op, input int addr, input int n, input int seed,
                       input int extra, input int exp_busy, input string req);
        int s;
        s = busy_run;
        frame(op, addr, n, seed, extra);
        wait_idle();
        chk(busy_run - s == exp_busy, req, busy_run - s, exp_busy);
    endtask

    task automatic model_page(input int op, input int addr, input int n, input int seed);
        logic [7:0] d [PB];
        bit v [PB];
        int base, off;
        base = (addr / PB) * PB; off = addr % PB;
        for (int j = 0; j < PB; j++) begin v[j] = 1'b0; d[j] = 8'h00; end
        for (int k = 0; k < n; k++) begin
            v[(off + k) % PB] = 1'b1;
            d[(off + k) % PB] = bval(seed, k);
        end
        for (int j = 0; j < PB; j++) begin
            if (op == 3) model[base + j] = v[j] ? d[j] : 8'hFF;
            else if (op == 4) model[base + j] = v[j] ? (model[base + j] & d[j]) : model[base + j];
            else model[base + j] = 8'hFF;
        end
    endtask

    task automatic check_page(input int page, input string req);
        for (int b = 0; b < PB; b++) begin
            @(negedge clk) rd_addr = AW'(page * PB + b);
            @(negedge clk) chk(rd_data === model[page * PB + b], req,
                               int'(rd_data), int'(model[page * PB + b]));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0, "R1 busy", int'(busy), 0);
        chk(wel === 1'b0, "R1 wel", int'(wel), 0);

        frame(1, 0, 0, 0, 0);
        chk(wel === 1'b1, "R2 enable", int'(wel), 1);
        frame(2, 0, 0, 0, 0);
        chk(wel === 1'b0, "R2 disable", int'(wel), 0);

        run(6, 70, 0, 0, 0, 0, "R3 no latch");

        frame(1, 0, 0, 0, 0);
        run(6, 5, 0, 0, 0, T_SE, "R7 sector0 time");
        chk(wel === 1'b0, "R12 end clear", int'(wel), 0);
        frame(1, 0, 0, 0, 0);
        run(6, 70, 0, 0, 0, T_SE, "R7 sector1 time");
        for (int j = 0; j < DEP; j++) model[j] = 8'hFF;
        for (int p = 0; p < PG; p++) check_page(p, "R7 erased");

        frame(2, 0, 0, 0, 0);
        run(3, 2 * PB + 3, 5, 99, 0, 0, "R3 rewrite refused");
        check_page(2, "R3 unchanged");

        frame(1, 0, 0, 0, 0);
        run(3, 2 * PB + 3, 5, 1, 0, T_PW, "R4 time");
        model_page(3, 2 * PB + 3, 5, 1);
        check_page(2, "R4 data");

        frame(1, 0, 0, 0, 0);
        run(4, 2 * PB, 16, 2, 0, T_PPB + 16 * T_PPY, "R5 time full");
        model_page(4, 2 * PB, 16, 2);
        check_page(2, "R5 and");

        frame(1, 0, 0, 0, 0);
        run(4, 5 * PB + 7, 3, 3, 0, T_PPB + 3 * T_PPY, "R5 time n3");
        model_page(4, 5 * PB + 7, 3, 3);
        check_page(5, "R5 partial page");

        frame(1, 0, 0, 0, 0);
        run(3, 6 * PB + 12, 6, 4, 0, T_PW, "R8 wrap time");
        model_page(3, 6 * PB + 12, 6, 4);
        check_page(6, "R8 wrap");

        frame(1, 0, 0, 0, 0);
        run(4, 2 * PB + 3, 20, 5, 0, T_PPB + 16 * T_PPY, "R8 overlong time");
        model_page(4, 2 * PB + 3, 20, 5);
        check_page(2, "R8 last kept");

        frame(1, 0, 0, 0, 0);
        run(5, 2 * PB + 9, 0, 0, 0, T_PE, "R6 time");
        model_page(5, 2 * PB, 0, 0);
        check_page(1, "R6 neighbour");
        check_page(2, "R6 erased");
        check_page(3, "R6 neighbour");

        frame(1, 0, 0, 0, 0);
        run(3, 4 * PB, 2, 6, 3, 0, "R9 partial byte");
        chk(wel === 1'b1, "R12 kept after refuse", int'(wel), 1);
        run(4, 4 * PB, 0, 0, 0, 0, "R9 no data");
        check_page(4, "R9 unchanged");

        wp_n = 1'b0;
        run(3, 1 * PB, 4, 7, 0, 0, "R10 rewrite blocked");
        run(5, 0, 0, 0, 0, 0, "R10 erase blocked");
        run(6, 3, 0, 0, 0, 0, "R10 sector blocked");
        check_page(1, "R10 unchanged");
        run(3, 5 * PB, 4, 8, 0, T_PW, "R10 other sector");
        model_page(3, 5 * PB, 4, 8);
        check_page(5, "R10 other data");
        wp_n = 1'b1;
        frame(1, 0, 0, 0, 0);
        run(3, 1 * PB + 2, 4, 7, 0, T_PW, "R10 unprotected");
        model_page(3, 1 * PB + 2, 4, 7);
        check_page(1, "R10 unprotected data");

        frame(1, 0, 0, 0, 0);
        begin
            int s;
            s = busy_run;
            frame(3, 7 * PB, 3, 9, 0);
            frame(4, 3 * PB, 1, 10, 0);
            wait_idle();
            chk(busy_run - s == T_PW, "R11 duration", busy_run - s, T_PW);
        end
        chk(wel === 1'b0, "R12 after drop", int'(wel), 0);
        model_page(3, 7 * PB, 3, 9);
        check_page(7, "R11 running result");
        check_page(3, "R11 dropped");

        @(negedge clk) rd_addr = AW'(7 * PB);
        @(negedge clk) chk(rd_data === model[7 * PB], "R13 latency", int'(rd_data), int'(model[7 * PB]));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule